// File: doc/BRIEF.md
# PCIe Device Power-State Sequencer

This block follows the function power state of a PCIe endpoint and orders the housekeeping that comes after a fundamental reset. It watches configuration writes to two registers and the active-low fundamental reset input. It also watches a clock-valid indication from the reference clock PLL and the completion of a non-volatile memory (NVM) reload. From these it drives an internal power-good, a one-cycle NVM reload request, the PHY reset, a wake-enable flag, a link-training enable, a configuration-ready flag, and a request for the link to enter L1.

The reset-driven path runs D3 → Dr → D0u → D0a. When the fundamental reset is released, three timers start. The power-good timer advances only on cycles where the clock is reported stable. When power-good rises, the block requests an NVM reload, holds the PHY in reset and clears wake enable. When the reload finishes, the PHY is released and wake enable takes the value that the NVM supplied. The device then rests in D0u until software enables memory access. A power-state write of 11 in D0a sends it to D3, where it stays until the next fundamental reset.

All inputs are synchronous to `clk`. The fundamental reset is assumed to be synchronized upstream. The three delays are static control pins. No input or output carries streaming data, so every pin is plain level or pulse control, with no valid/ready handshake and no back-pressure.

Top module: `pcie_pm_seq`

## Requirements
- R1: In D0a, a configuration write to the power-management control address with data bits [1:0] equal to 11 moves `dstate` to D3 at the next clock edge, and `link_l1_req` is high exactly while `dstate` is D3. The `dstate` encoding is D0a=0, D0u=1, D3=2, Dr=3.
- R2: If `perst_n` is sampled low in any state, then at the next edge `dstate` is Dr, `phy_rst` is 1, and `int_pwr_good`, `train_en` and `cfg_ready` are 0.
- R3: `int_pwr_good` rises at the (`pg_dly`+1)-th clock edge after release at which `perst_n` and `clk_stable` are both high. Edges with `clk_stable` low are not counted.
- R4: One edge after `int_pwr_good` rises, `nvm_start` is high for exactly one cycle, `wake_en` is 0 and `phy_rst` is 1.
- R5: While a reload is pending, `nvm_done` high at an edge releases `phy_rst` and moves `dstate` from Dr to D0u. `nvm_done` seen while no reload is pending is ignored.
- R6: When the reload completes, `wake_en` takes the value of `nvm_wake_cfg` sampled with `nvm_done`, and it keeps that value until the next power-good rise.
- R7: `train_en` rises at the (`trn_dly`+1)-th clock edge after release, independent of `clk_stable`.
- R8: In D0u, a write to the command address with data bit 1 set moves `dstate` to D0a. The same write with bit 1 clear leaves D0u.
- R9: Power-state writes of 01 or 10, and writes to any other address, leave `dstate` unchanged.
- R10: `cfg_ready` rises at the (`rsp_dly`+1)-th clock edge after release.
- R11: Asserting `perst_n` low during a pending reload aborts it. A later `nvm_done` does not release the PHY until a new power-good and a new reload request have occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| perst_n | input | 1 | PCIe fundamental reset, active low, synchronized |
| clk_stable | input | 1 | Internal PCIe clock reported stable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration write address |
| cfg_wdata | input | DATA_W | Configuration write data |
| pg_dly | input | CNT_W | Release-to-power-good delay |
| trn_dly | input | CNT_W | Release-to-training delay |
| rsp_dly | input | CNT_W | Release-to-config-response delay |
| nvm_done | input | 1 | NVM reload finished |
| nvm_wake_cfg | input | 1 | Wake setting returned by the NVM reload |
| dstate | output | 2 | Current D-state code |
| int_pwr_good | output | 1 | Internal power-good |
| nvm_start | output | 1 | One-cycle NVM reload request |
| phy_rst | output | 1 | PHY reset, active high |
| wake_en | output | 1 | Wake enable |
| train_en | output | 1 | Link training allowed |
| cfg_ready | output | 1 | Configuration responses allowed |
| link_l1_req | output | 1 | Request for the link to enter L1 |

## Verification
The bench builds the block with its default widths: a 12-bit address, 32-bit data and 16-bit counters. It drives the delay pins with 6 for power-good, 10 for training and 14 for configuration response. These short, distinct delays put each threshold within a few cycles, so the exact edge on which each timer expires can be checked on both sides. Because the three delays differ, a mixed-up timer shows up as a miss. A clock-stable gap in the middle of the power-good count shows that only stable cycles advance that timer, while the other two keep counting.

// File: rtl/pm_seq_pkg.sv
package pm_seq_pkg;
  typedef enum logic [1:0] {
    DS_D0A = 2'd0,
    DS_D0U = 2'd1,
    DS_D3  = 2'd2,
    DS_DR  = 2'd3
  } dstate_t;

  localparam int NUM_TMR = 3;
  localparam int TMR_PG  = 0;
  localparam int TMR_TRN = 1;
  localparam int TMR_RSP = 2;

  localparam logic [1:0] PS_D3_CODE = 2'b11;
endpackage

// File: rtl/pm_dly_timer.sv
module pm_dly_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  // cnt walks 0..limit on enabled edges; the edge after reaching limit flags expiry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (clr) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (en && !expired) begin
      if (cnt == limit) expired <= 1'b1;
      else              cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pm_cfg_decode.sv
module pm_cfg_decode #(
  parameter int              ADDR_W   = 12,
  parameter int              DATA_W   = 32,
  parameter logic [ADDR_W-1:0] PM_ADDR  = 12'h044,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 12'h004
) (
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              ev_d3_req,
  output logic              ev_mem_en
);
  import pm_seq_pkg::*;

  localparam int PS_LSB  = 0;
  localparam int MEM_BIT = 1;

  logic [1:0] ps_field;
  logic       hit_pm;
  logic       hit_cmd;

  always_comb begin
    ps_field  = cfg_wdata[PS_LSB +: 2];
    hit_pm    = cfg_wr && (cfg_addr == PM_ADDR);
    hit_cmd   = cfg_wr && (cfg_addr == CMD_ADDR);
    ev_d3_req = hit_pm && (ps_field == PS_D3_CODE);
    ev_mem_en = hit_cmd && cfg_wdata[MEM_BIT];
  end
endmodule

// File: rtl/pm_state_ctl.sv
module pm_state_ctl (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 perst_n,
  input  logic                 pg,
  input  logic                 ev_d3_req,
  input  logic                 ev_mem_en,
  input  logic                 nvm_done,
  input  logic                 nvm_wake_cfg,
  output pm_seq_pkg::dstate_t  state,
  output logic                 nvm_start,
  output logic                 phy_rst,
  output logic                 wake_en,
  output logic                 link_l1_req
);
  import pm_seq_pkg::*;

  logic pg_seen;
  logic reload_busy;
  logic pg_rise;

  assign pg_rise     = pg && !pg_seen;
  assign link_l1_req = (state == DS_D3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= DS_DR;
      pg_seen     <= 1'b0;
      reload_busy <= 1'b0;
      nvm_start   <= 1'b0;
      phy_rst     <= 1'b1;
      wake_en     <= 1'b0;
    end else if (!perst_n) begin
      // fundamental reset: abort any reload, keep wake setting
      state       <= DS_DR;
      pg_seen     <= 1'b0;
      reload_busy <= 1'b0;
      nvm_start   <= 1'b0;
      phy_rst     <= 1'b1;
    end else begin
      nvm_start <= 1'b0;
      if (pg_rise) begin
        pg_seen     <= 1'b1;
        reload_busy <= 1'b1;
        nvm_start   <= 1'b1;
        phy_rst     <= 1'b1;
        wake_en     <= 1'b0;
      end else if (reload_busy && nvm_done) begin
        reload_busy <= 1'b0;
        phy_rst     <= 1'b0;
        wake_en     <= nvm_wake_cfg;
        state       <= DS_D0U;
      end else begin
        case (state)
          DS_D0U:  if (ev_mem_en) state <= DS_D0A;
          DS_D0A:  if (ev_d3_req) state <= DS_D3;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pcie_pm_seq.sv
module pcie_pm_seq #(
  parameter int                ADDR_W   = 12,
  parameter int                DATA_W   = 32,
  parameter int                CNT_W    = 16,
  parameter logic [ADDR_W-1:0] PM_ADDR  = 12'h044,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 12'h004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              perst_n,
  input  logic              clk_stable,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [CNT_W-1:0]  pg_dly,
  input  logic [CNT_W-1:0]  trn_dly,
  input  logic [CNT_W-1:0]  rsp_dly,
  input  logic              nvm_done,
  input  logic              nvm_wake_cfg,
  output logic [1:0]        dstate,
  output logic              int_pwr_good,
  output logic              nvm_start,
  output logic              phy_rst,
  output logic              wake_en,
  output logic              train_en,
  output logic              cfg_ready,
  output logic              link_l1_req
);
  import pm_seq_pkg::*;

  logic [CNT_W-1:0] tmr_lim [NUM_TMR];
  logic             tmr_en  [NUM_TMR];
  logic             tmr_exp [NUM_TMR];

  always_comb begin
    tmr_lim[TMR_PG]  = pg_dly;
    tmr_lim[TMR_TRN] = trn_dly;
    tmr_lim[TMR_RSP] = rsp_dly;
    tmr_en[TMR_PG]   = clk_stable;
    tmr_en[TMR_TRN]  = 1'b1;
    tmr_en[TMR_RSP]  = 1'b1;
  end

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    pm_dly_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (!perst_n),
      .en      (tmr_en[g]),
      .limit   (tmr_lim[g]),
      .expired (tmr_exp[g])
    );
  end

  logic ev_d3_req;
  logic ev_mem_en;

  pm_cfg_decode #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PM_ADDR  (PM_ADDR),
    .CMD_ADDR (CMD_ADDR)
  ) u_dec (
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .ev_d3_req (ev_d3_req),
    .ev_mem_en (ev_mem_en)
  );

  dstate_t st;

  pm_state_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .perst_n      (perst_n),
    .pg           (tmr_exp[TMR_PG]),
    .ev_d3_req    (ev_d3_req),
    .ev_mem_en    (ev_mem_en),
    .nvm_done     (nvm_done),
    .nvm_wake_cfg (nvm_wake_cfg),
    .state        (st),
    .nvm_start    (nvm_start),
    .phy_rst      (phy_rst),
    .wake_en      (wake_en),
    .link_l1_req  (link_l1_req)
  );

  assign dstate       = st;
  assign int_pwr_good = tmr_exp[TMR_PG];
  assign train_en     = tmr_exp[TMR_TRN];
  assign cfg_ready    = tmr_exp[TMR_RSP];
endmodule

// File: rtl/pcie_pm_seq_chk.sv
module pcie_pm_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       perst_n,
  input logic       clk_stable,
  input logic [1:0] dstate,
  input logic       int_pwr_good,
  input logic       nvm_start,
  input logic       phy_rst,
  input logic       wake_en,
  input logic       train_en,
  input logic       cfg_ready,
  input logic       link_l1_req
);
  localparam logic [1:0] C_D0A = 2'd0;
  localparam logic [1:0] C_D0U = 2'd1;
  localparam logic [1:0] C_D3  = 2'd2;
  localparam logic [1:0] C_DR  = 2'd3;

  a_r1_d3_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (dstate == C_D3) |-> ($past(dstate) == C_D3 || $past(dstate) == C_D0A));

  a_r1_l1_req: assert property (@(posedge clk) disable iff (!rst_n)
    link_l1_req |-> (dstate == C_D3));

  a_r2_perst_dr: assert property (@(posedge clk) disable iff (!rst_n)
    !perst_n |=> (dstate == C_DR && phy_rst && !int_pwr_good && !train_en && !cfg_ready));

  a_r3_pg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_pwr_good) |-> ($past(clk_stable) && $past(perst_n)));

  a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_start |=> !nvm_start);

  a_r4_start_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_start |-> (phy_rst && !wake_en && int_pwr_good));

  a_r5_phy_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_rst) |-> (dstate == C_D0U));

  a_r6_wake_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_en) |-> $fell(phy_rst));

  a_r8_d0a_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (dstate == C_D0A) |-> ($past(dstate) == C_D0A || $past(dstate) == C_D0U));

  a_r11_active_pg: assert property (@(posedge clk) disable iff (!rst_n)
    (dstate != C_DR) |-> (int_pwr_good && !phy_rst));
endmodule

bind pcie_pm_seq pcie_pm_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .perst_n      (perst_n),
  .clk_stable   (clk_stable),
  .dstate       (dstate),
  .int_pwr_good (int_pwr_good),
  .nvm_start    (nvm_start),
  .phy_rst      (phy_rst),
  .wake_en      (wake_en),
  .train_en     (train_en),
  .cfg_ready    (cfg_ready),
  .link_l1_req  (link_l1_req)
);

// File: tb/tb_pcie_pm_seq.sv
module tb_pcie_pm_seq;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam logic [ADDR_W-1:0] PM_A  = 12'h044;
  localparam logic [ADDR_W-1:0] CMD_A = 12'h004;
  localparam int PG  = 6;
  localparam int TRN = 10;
  localparam int RSP = 14;
  localparam logic [1:0] E_D0A = 2'd0, E_D0U = 2'd1, E_D3 = 2'd2, E_DR = 2'd3;

  logic clk = 1'b0;
  logic rst_n, perst_n, clk_stable, cfg_wr, nvm_done, nvm_wake_cfg;
  logic [ADDR_W-1:0] cfg_addr;
  logic [DATA_W-1:0] cfg_wdata;
  logic [1:0] dstate;
  logic int_pwr_good, nvm_start, phy_rst, wake_en, train_en, cfg_ready, link_l1_req;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pcie_pm_seq dut (
    .clk(clk), .rst_n(rst_n), .perst_n(perst_n), .clk_stable(clk_stable),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pg_dly(CNT_W'(PG)), .trn_dly(CNT_W'(TRN)), .rsp_dly(CNT_W'(RSP)),
    .nvm_done(nvm_done), .nvm_wake_cfg(nvm_wake_cfg),
    .dstate(dstate), .int_pwr_good(int_pwr_good), .nvm_start(nvm_start),
    .phy_rst(phy_rst), .wake_en(wake_en), .train_en(train_en),
    .cfg_ready(cfg_ready), .link_l1_req(link_l1_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick(1);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  // full bring-up to D0u; checks R3, R4, R5, R6 along the way
  task automatic bring_up(input logic wake);
    perst_n = 1'b0; tick(2);
    perst_n = 1'b1; clk_stable = 1'b1;
    tick(PG);
    chk("R3 pg before delay", int_pwr_good, 0);
    tick(1);
    chk("R3 pg at delay", int_pwr_good, 1);
    tick(1);
    chk("R4 nvm_start pulse", nvm_start, 1);
    chk("R4 wake cleared", wake_en, 0);
    chk("R4 phy held", phy_rst, 1);
    nvm_done = 1'b1; nvm_wake_cfg = wake;
    tick(1);
    nvm_done = 1'b0;
    chk("R4 nvm_start one cycle", nvm_start, 0);
    chk("R5 phy released", phy_rst, 0);
    chk("R5 state D0u", dstate, E_D0U);
    chk("R6 wake from nvm", wake_en, wake);
  endtask

  task automatic t_reset_state();
    chk("R2 reset Dr", dstate, E_DR);
    chk("R2 reset phy", phy_rst, 1);
    chk("R2 reset pg", int_pwr_good, 0);
    chk("R2 reset ready", cfg_ready, 0);
  endtask

  task automatic t_timers();
    perst_n = 1'b0; tick(2);
    perst_n = 1'b1; clk_stable = 1'b1;
    tick(TRN);
    chk("R7 train before", train_en, 0);
    tick(1);
    chk("R7 train at delay", train_en, 1);
    tick(RSP - TRN - 1);
    chk("R10 ready before", cfg_ready, 0);
    tick(1);
    chk("R10 ready at delay", cfg_ready, 1);
  endtask

  task automatic t_stable_gap();
    perst_n = 1'b0; tick(2);
    perst_n = 1'b1; clk_stable = 1'b1;
    tick(2);
    clk_stable = 1'b0; tick(3);
    clk_stable = 1'b1;
    tick(PG - 2);
    chk("R3 gap not counted", int_pwr_good, 0);
    tick(1);
    chk("R3 pg after gap", int_pwr_good, 1);
    chk("R7 training ignores gap", train_en, 0);
  endtask

  task automatic t_states();
    bring_up(1'b1);
    cfg_write(CMD_A, 32'h0000_0004);
    chk("R8 bit1 clear stays D0u", dstate, E_D0U);
    cfg_write(PM_A, 32'h0000_0003);
    chk("R1 d3 write ignored in D0u", dstate, E_D0U);
    cfg_write(CMD_A, 32'h0000_0002);
    chk("R8 mem enable D0a", dstate, E_D0A);
    cfg_write(PM_A, 32'h0000_0001);
    chk("R9 ps 01 ignored", dstate, E_D0A);
    cfg_write(PM_A, 32'h0000_0002);
    chk("R9 ps 10 ignored", dstate, E_D0A);
    cfg_write(12'h048, 32'h0000_0003);
    chk("R9 other addr ignored", dstate, E_D0A);
    chk("R1 no l1 in D0a", link_l1_req, 0);
    cfg_write(PM_A, 32'h0000_0003);
    chk("R1 D3 entry", dstate, E_D3);
    chk("R1 l1 request", link_l1_req, 1);
    chk("R6 wake kept in D3", wake_en, 1);
    perst_n = 1'b0; tick(1);
    chk("R2 perst to Dr", dstate, E_DR);
    chk("R2 l1 dropped", link_l1_req, 0);
    chk("R2 train cleared", train_en, 0);
    chk("R6 wake kept in Dr", wake_en, 1);
  endtask

  task automatic t_stray_done();
    perst_n = 1'b0; tick(2);
    perst_n = 1'b1; clk_stable = 1'b1;
    tick(2);
    nvm_done = 1'b1; nvm_wake_cfg = 1'b1; tick(1); nvm_done = 1'b0;
    chk("R5 stray done ignored phy", phy_rst, 1);
    chk("R5 stray done ignored state", dstate, E_DR);
  endtask

  task automatic t_abort();
    perst_n = 1'b0; tick(2);
    perst_n = 1'b1; clk_stable = 1'b1;
    tick(PG + 2);
    chk("R11 reload pending", nvm_start, 1);
    perst_n = 1'b0; tick(1);
    nvm_done = 1'b1; tick(1); nvm_done = 1'b0;
    perst_n = 1'b1; tick(1);
    nvm_done = 1'b1; tick(1); nvm_done = 1'b0;
    chk("R11 abort keeps phy", phy_rst, 1);
    chk("R11 abort state Dr", dstate, E_DR);
    bring_up(1'b0);
    chk("R11 recovered D0u", dstate, E_D0U);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; perst_n = 1'b0; clk_stable = 1'b0; cfg_wr = 1'b0;
    cfg_addr = '0; cfg_wdata = '0; nvm_done = 1'b0; nvm_wake_cfg = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset_state();
    t_timers();
    t_stable_gap();
    t_states();
    t_stray_done();
    t_abort();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule